// File: doc/BRIEF.md
# Indirect SerDes Register Access Engine

This block gives a host processor indirect access to a large array of 16-bit SerDes configuration registers through only two words of address space: a command word and a data word. The host places an access request in the command word with its start flag set. The engine marks itself busy, works on the request for a fixed number of cycles, and then clears the flag. A write takes its value from the data word. A read leaves its result in the data word.

The storage is organised as several backing SerDes, each with 64 pages of 32 registers. In direct mode the SerDes index in the command names a backing SerDes. In front-end mode the index names one of 14 logical SerDes, and two extension bits widen the page number to a logical page range of 0..191. The engine then folds that logical page onto one of up to three backing SerDes. Accesses that land outside the implemented storage still complete. They change nothing, and a read of such a location returns zero.

Top module: `serdes_indirect_access`

## Requirements
- R1: The command word at byte offset 0 holds these fields: bit 0 start/busy, bit 1 direction (1 = write, 0 = read), bits 6:2 SerDes index, bits 12:7 page, bits 17:13 register, and bits 19:18 page extension, which only front-end mode uses. Reading offset 0 returns the bits 19:1 of the last accepted command, with bit 0 showing live busy.
- R2: The data word sits at byte offset 4. Only bits 15:0 are stored. Bits 31:16 always read as 0.
- R3: A write command stores the current data word into the addressed register. A read command loads the addressed register's value into the data word when the access completes.
- R4: After a command is accepted, busy reads 1 for exactly ACCESS_CYCLES cycles and then reads 0 until the next accepted command.
- R5: A command word written with bit 0 clear, or written while busy is set, is ignored. A data word written while busy is set is also ignored.
- R6: After reset, busy is 0, both words read 0, and every storage register reads 0.
- R7: In direct mode the backing SerDes is the index field, the backing page is the page field, and the extension bits have no effect.
- R8: In front-end mode, logical SerDes 0..13 have base backing indices 0,1,2,3,6,7,10,11,14,15,18,19,22,23. Logical SerDes 0 and 1 always use their base, whatever the logical page.
- R9: In front-end mode the logical page is {extension, page}. The backing page is the logical page modulo 64. Odd logical SerDes from 3 upward add (logical page >> 6) to the base. Even logical SerDes from 2 upward add (logical page >> 7).
- R10: An access is out of range when the backing index is at least BACK_CNT, when a front-end logical index is 14 or more, or when a front-end extension is 3. Such an access still completes after ACCESS_CYCLES cycles and leaves storage unchanged. If it is a read, the data word becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for one cycle |
| host_addr | input | 3 | Byte offset: 0 command, 4 data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for host_addr |

## Verification
The bench targets the places where the front-end fold can silently go wrong. It writes through an even logical SerDes and reads the same register back through the neighbouring odd one, which shares that backing SerDes. A wrong base table or wrong shift would miss the data or hit a neighbour. It also probes accesses one past the last backing SerDes and with the forbidden extension value. An engine without range checks would corrupt other storage or return stale data. It fires a second command, and a data write, while busy is set. A design that accepts them would overwrite a pending access or the read result. Finally, it counts the busy cycles exactly, because an off-by-one counter would break host polling loops that depend on the access latency.

// File: rtl/sds_acc_pkg.sv
package sds_acc_pkg;
    localparam int CMD_W    = 20;
    localparam int VAL_W    = 16;
    localparam int SDS_W    = 5;
    localparam int PAGE_W   = 6;
    localparam int REG_W    = 5;
    localparam int EXT_W    = 2;
    localparam int BIT_GO   = 0;
    localparam int BIT_WR   = 1;
    localparam int SDS_LSB  = 2;
    localparam int PAGE_LSB = 7;
    localparam int REG_LSB  = 13;
    localparam int EXT_LSB  = 18;
    localparam int FE_LOGICAL_CNT = 14;
    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_DATA = 3'd4;

    typedef struct packed {
        logic              wr;
        logic [SDS_W-1:0]  sds;
        logic [PAGE_W-1:0] page;
        logic [REG_W-1:0]  regn;
        logic [EXT_W-1:0]  ext;
    } cmd_t;
endpackage

// File: rtl/sds_target_map.sv
module sds_target_map
    import sds_acc_pkg::*;
#(
    parameter bit FRONT_END = 1'b0,
    parameter int BACK_CNT  = 2,
    parameter int IDX_W     = 1
) (
    input  cmd_t              cmd,
    output logic              in_range,
    output logic [IDX_W-1:0]  back_idx,
    output logic [PAGE_W-1:0] back_page
);
    // Backing page is the low six bits of the logical page (R9)
    assign back_page = cmd.page;

    generate
        if (FRONT_END) begin : g_front
            logic [5:0] base;
            logic [5:0] step;
            logic [5:0] full;
            logic       lane_ok;
            logic       unused_bits;

            assign unused_bits = cmd.wr ^ (^cmd.regn);

            always_comb begin
                // R8: base index is 4*(n/2)-2+(n&1) for n >= 2
                if (cmd.sds < 5'd2) begin
                    base = {1'b0, cmd.sds};
                end else begin
                    base = {cmd.sds[4:1], 2'b00} - 6'd2 + {5'd0, cmd.sds[0]};
                end
                // R9: odd lanes spread over three, even lanes over two
                if (cmd.sds < 5'd2) begin
                    step = 6'd0;
                end else if (cmd.sds[0]) begin
                    step = {4'd0, cmd.ext};
                end else begin
                    step = {5'd0, cmd.ext[1]};
                end
                full    = base + step;
                lane_ok = (cmd.sds < 5'(FE_LOGICAL_CNT)) && (cmd.ext != 2'b11);
            end

            assign in_range = lane_ok && (int'(full) < BACK_CNT);
            assign back_idx = full[IDX_W-1:0];
        end else begin : g_direct
            logic unused_bits;
            assign unused_bits = cmd.wr ^ (^cmd.regn) ^ (^cmd.ext);
            assign in_range = int'(cmd.sds) < BACK_CNT;
            assign back_idx = cmd.sds[IDX_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/sds_reg_store.sv
module sds_reg_store
    import sds_acc_pkg::*;
#(
    parameter int BACK_CNT = 2,
    parameter int IDX_W    = 1,
    localparam int ADDR_W  = IDX_W + PAGE_W + REG_W,
    localparam int DEPTH   = BACK_CNT << (PAGE_W + REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VAL_W-1:0]  wdata,
    output logic [VAL_W-1:0]  rdata
);
    logic [VAL_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0] valid_q;

    // Unwritten words read as zero, so reset needs only the valid vector (R6)
    assign rdata = valid_q[addr] ? mem_q[addr] : '0;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[addr] <= 1'b1;
        end
    end

    // R10: storage only moves when the engine commits an in-range write
    a_r10_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/serdes_indirect_access.sv
module serdes_indirect_access
    import sds_acc_pkg::*;
#(
    parameter bit FRONT_END     = 1'b0,
    parameter int BACK_CNT      = 2,
    parameter int ACCESS_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);
    localparam int IDX_W  = (BACK_CNT > 1) ? $clog2(BACK_CNT) : 1;
    localparam int CNT_W  = $clog2(ACCESS_CYCLES);
    localparam int ADDR_W = IDX_W + PAGE_W + REG_W;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] cmd;
        logic [VAL_W-1:0] data;
    } eng_t;

    eng_t st_d, st_q;

    cmd_t              dec_cmd;
    logic              tgt_ok;
    logic [IDX_W-1:0]  tgt_idx;
    logic [PAGE_W-1:0] tgt_page;
    logic              store_wr;
    logic [VAL_W-1:0]  store_rdata;
    logic              at_end;
    logic [11:0]       unused_wdata;

    assign unused_wdata = host_wdata[31:20];

    assign dec_cmd = '{wr:   st_q.cmd[BIT_WR],
                       sds:  st_q.cmd[SDS_LSB +: SDS_W],
                       page: st_q.cmd[PAGE_LSB +: PAGE_W],
                       regn: st_q.cmd[REG_LSB +: REG_W],
                       ext:  st_q.cmd[EXT_LSB +: EXT_W]};

    sds_target_map #(
        .FRONT_END (FRONT_END),
        .BACK_CNT  (BACK_CNT),
        .IDX_W     (IDX_W)
    ) map_i (
        .cmd       (dec_cmd),
        .in_range  (tgt_ok),
        .back_idx  (tgt_idx),
        .back_page (tgt_page)
    );

    sds_reg_store #(
        .BACK_CNT (BACK_CNT),
        .IDX_W    (IDX_W)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (store_wr),
        .addr  ({tgt_idx, tgt_page, dec_cmd.regn}),
        .wdata (st_q.data),
        .rdata (store_rdata)
    );

    assign at_end = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d     = st_q;
        store_wr = 1'b0;
        if (st_q.busy) begin
            if (at_end) begin
                st_d.busy = 1'b0;
                if (dec_cmd.wr) begin
                    store_wr = tgt_ok;
                end else begin
                    st_d.data = tgt_ok ? store_rdata : '0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (host_wr_en) begin
            if (host_addr == OFS_CMD && host_wdata[BIT_GO]) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(ACCESS_CYCLES - 1);
                st_d.cmd  = host_wdata[CMD_W-1:0];
            end else if (host_addr == OFS_DATA) begin
                st_d.data = host_wdata[VAL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == OFS_CMD) begin
            host_rdata = {12'd0, st_q.cmd[CMD_W-1:1], st_q.busy};
        end else if (host_addr == OFS_DATA) begin
            host_rdata = {16'd0, st_q.data};
        end
    end

    a_r4_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> st_q.busy);

    a_r4_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> !st_q.busy);

    a_r5_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.cmd));

    a_r5_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> $stable(st_q.data));

    a_r10_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !dec_cmd.wr && !tgt_ok) |=> (st_q.data == '0));

    a_r8_low_lane_base: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && tgt_ok && dec_cmd.sds < 5'd2) |->
            (int'(tgt_idx) == int'(dec_cmd.sds)));
endmodule

// File: tb/serdes_indirect_access_tb_top.sv
module serdes_indirect_access_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] rdata_fe;
    logic [31:0] rdata_dir;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    serdes_indirect_access #(
        .FRONT_END     (1'b1),
        .BACK_CNT      (8),
        .ACCESS_CYCLES (4)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (rdata_fe)
    );

    serdes_indirect_access dut_dir_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (rdata_dir)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit wr, input int sds, input int page,
                                           input int regn, input int ext);
        return {12'd0, 2'(ext), 5'(regn), 6'(page), 5'(sds), wr, 1'b1};
    endfunction

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] fe, output logic [31:0] dir);
        host_addr = a;
        #1;
        fe  = rdata_fe;
        dir = rdata_dir;
    endtask

    task automatic wait_idle();
        logic [31:0] fe, dir;
        for (int i = 0; i < 50; i++) begin
            peek(3'd0, fe, dir);
            if (!fe[0] && !dir[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic sds_write(input int sds, input int page, input int regn, input int ext,
                             input logic [15:0] v);
        host_wr(3'd4, {16'd0, v});
        host_wr(3'd0, mk_cmd(1'b1, sds, page, regn, ext));
        wait_idle();
    endtask

    task automatic sds_read(input int sds, input int page, input int regn, input int ext,
                            output logic [31:0] fe, output logic [31:0] dir);
        host_wr(3'd0, mk_cmd(1'b0, sds, page, regn, ext));
        wait_idle();
        peek(3'd4, fe, dir);
    endtask

    task automatic t_reset();
        logic [31:0] fe, dir;
        peek(3'd0, fe, dir);
        check("R6 cmd word after reset", fe, 32'd0);
        peek(3'd4, fe, dir);
        check("R6 data word after reset", fe, 32'd0);
        sds_read(0, 0, 0, 0, fe, dir);
        check("R6 storage after reset", fe, 32'd0);
    endtask

    task automatic t_roundtrip();
        logic [31:0] fe, dir;
        sds_write(0, 3, 7, 0, 16'hBEEF);
        sds_read(0, 3, 7, 0, fe, dir);
        check("R3 write then read back", fe, 32'h0000BEEF);
        peek(3'd0, fe, dir);
        check("R1 cmd readback of read command", fe, mk_cmd(1'b0, 0, 3, 7, 0) & 32'hFFFF_FFFE);
    endtask

    task automatic t_latency();
        logic [31:0] fe, dir;
        int n = 0;
        host_wr(3'd0, mk_cmd(1'b0, 0, 3, 7, 0));
        for (int i = 0; i < 20; i++) begin
            peek(3'd0, fe, dir);
            if (fe[0]) n++;
            else break;
            @(negedge clk);
        end
        check("R4 busy cycle count", 32'(n), 32'd4);
        wait_idle();
    endtask

    task automatic t_upper_bits();
        logic [31:0] fe, dir;
        host_wr(3'd4, 32'hFFFF_1234);
        peek(3'd4, fe, dir);
        check("R2 data word upper bits", fe, 32'h0000_1234);
    endtask

    task automatic t_low_lane_alias();
        logic [31:0] fe, dir;
        sds_write(0, 0, 1, 0, 16'h1111);
        sds_read(0, 0, 1, 2, fe, dir);
        check("R8 lane 0 page 128 hits base", fe, 32'h1111);
        sds_read(1, 0, 1, 1, fe, dir);
        check("R8 lane 1 page 64 on base 1 empty", fe, 32'h0);
    endtask

    task automatic t_spread();
        logic [31:0] fe, dir;
        sds_write(3, 5, 2, 2, 16'hA5A5);
        sds_read(3, 5, 2, 2, fe, dir);
        check("R9 odd lane third backing", fe, 32'hA5A5);
        sds_read(3, 5, 2, 1, fe, dir);
        check("R9 odd lane second backing separate", fe, 32'h0);
        sds_write(2, 9, 4, 2, 16'h3C3C);
        sds_read(3, 9, 4, 0, fe, dir);
        check("R9 even lane page 128 shares backing 3", fe, 32'h3C3C);
        sds_read(2, 9, 4, 1, fe, dir);
        check("R9 even lane page 64 stays on base", fe, 32'h0);
        sds_write(4, 1, 1, 0, 16'h0606);
        sds_read(4, 1, 1, 1, fe, dir);
        check("R8 lane 4 base 6", fe, 32'h0606);
    endtask

    task automatic t_out_of_range();
        logic [31:0] fe, dir;
        sds_write(5, 2, 2, 1, 16'h7777);
        host_wr(3'd4, 32'h0000_5555);
        sds_read(5, 2, 2, 1, fe, dir);
        check("R10 backing past end reads 0", fe, 32'h0);
        sds_read(5, 2, 2, 0, fe, dir);
        check("R10 lane 5 base untouched", fe, 32'h0);
        sds_write(1, 4, 4, 3, 16'h8888);
        sds_read(1, 4, 4, 0, fe, dir);
        check("R10 extension 3 leaves storage", fe, 32'h0);
        sds_read(14, 0, 0, 0, fe, dir);
        check("R10 logical index 14 reads 0", fe, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] fe, dir, prev;
        host_wr(3'd4, 32'h0000_5151);
        host_wr(3'd0, mk_cmd(1'b1, 0, 10, 10, 0));
        host_wr(3'd0, mk_cmd(1'b1, 0, 11, 11, 0));
        wait_idle();
        peek(3'd0, fe, dir);
        check("R5 second command ignored", fe, mk_cmd(1'b1, 0, 10, 10, 0) & 32'hFFFF_FFFE);
        sds_read(0, 11, 11, 0, fe, dir);
        check("R5 ignored target empty", fe, 32'h0);
        sds_read(0, 10, 10, 0, fe, dir);
        check("R5 first command stored", fe, 32'h5151);
        host_wr(3'd0, mk_cmd(1'b0, 0, 3, 7, 0));
        host_wr(3'd4, 32'h0000_9999);
        wait_idle();
        peek(3'd4, fe, dir);
        check("R5 data write during busy ignored", fe, 32'hBEEF);
        peek(3'd0, prev, dir);
        host_wr(3'd0, mk_cmd(1'b1, 2, 2, 2, 0) & 32'hFFFF_FFFE);
        peek(3'd0, fe, dir);
        check("R5 command without start ignored", fe, prev);
    endtask

    task automatic t_direct();
        logic [31:0] fe, dir;
        sds_write(1, 33, 31, 0, 16'h4242);
        sds_read(1, 33, 31, 0, fe, dir);
        check("R7 direct mode round trip", dir, 32'h4242);
        sds_read(1, 33, 31, 2, fe, dir);
        check("R7 direct mode ignores extension", dir, 32'h4242);
        sds_write(2, 1, 1, 0, 16'h6161);
        sds_read(2, 1, 1, 0, fe, dir);
        check("R10 direct index past end reads 0", dir, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_roundtrip();
        t_latency();
        t_upper_bits();
        t_low_lane_alias();
        t_spread();
        t_out_of_range();
        t_busy_ignore();
        t_direct();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule